// File: doc/BRIEF.md
# Selectable Data-Valid Indicator

This block folds three single-bit receive qualifiers into one registered data-valid bit: a signal-strength-above-threshold flag, a data-quality flag and a clock-recovery-lock flag. The flags arrive already synchronous to the block clock. A 2-bit policy field selects how they are combined. The four policies are:

- a constant high output;
- a hysteretic latch that sets when all three flags agree and clears only when none is left;
- a lock-gated OR of strength and quality;
- a direct copy of the quality flag.

The block sits between the demodulator's detectors and whatever consumes received bits. The policy trades reaction speed against robustness to noise. Reset comes in asynchronously, active low. Inside the block its release is synchronised over a parameterised number of flops before the core sees it.

Top module: `dv_valid_gen`

## Requirements
- R1: While `rst_n` is low the output is low, and it drops at once when `rst_n` falls; after `rst_n` rises the core stays in reset for SYNC_STAGES rising edges (default 2), so the first edge that can raise `valid_o` is edge SYNC_STAGES+1.
- R2: With `mode_i` = 2'b00 the output is high whatever the three flags are.
- R3: With `mode_i` = 2'b01 the output is set when `rssi_i`, `qual_i` and `lock_i` are all high.
- R4: With `mode_i` = 2'b01 a set output stays high while at least one of the three flags is high.
- R5: With `mode_i` = 2'b01 the output clears when all three flags are low.
- R6: With `mode_i` = 2'b10 the output equals `lock_i` AND (`rssi_i` OR `qual_i`).
- R7: With `mode_i` = 2'b11 the output equals `qual_i`.
- R8: The output is registered: it reflects the inputs present at the previous rising clock edge.
- R9: Whenever `mode_i` is not 2'b01 the hysteresis state is held clear. On entering 2'b01 the output therefore rises only if all three flags are high, and no state from an earlier slow period survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy select: 00 always, 01 slow, 10 medium, 11 fast |
| rssi_i | input | 1 | Signal strength above threshold |
| qual_i | input | 1 | Data-quality flag |
| lock_i | input | 1 | Clock-recovery lock flag |
| valid_o | output | 1 | Registered data-valid indication |

## Verification
On every cycle the assertions check the following:

- the constant-high, lock-gated and quality-following policies, each one cycle after the fact;
- the slow policy's set-on-all and clear-on-none edges;
- holding while any flag remains high;
- the fresh start on entry to the slow policy;
- a low output during reset.

The bench's directed sequences are what show the rest. These are the exact reset-release latency through the synchroniser, and the asynchronous drop of the output in mid-operation. They also cover long hold intervals where the flags change one at a time, and switches back and forth between policies with a stale latch value that must not reappear.

// File: rtl/dv_pkg.sv
package dv_pkg;

  localparam int unsigned DV_MODE_W = 2;

  typedef enum logic [DV_MODE_W-1:0] {
    DV_ALWAYS = 2'b00,
    DV_SLOW   = 2'b01,
    DV_MEDIUM = 2'b10,
    DV_FAST   = 2'b11
  } dv_mode_e;

  typedef struct packed {
    logic rssi;
    logic qual;
    logic lock;
  } dv_flags_t;

  localparam int unsigned DV_FLAG_W = $bits(dv_flags_t);

endpackage

// File: rtl/dv_rst_sync.sv
module dv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= 1'b1;
      end
      assign rst_core_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rst_core_n = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dv_hyst_latch.sv
module dv_hyst_latch
  import dv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active_i,
  input  dv_flags_t flags_i,
  output logic      state_d_o,
  output logic      state_q_o
);

  logic all_high;
  logic none_high;
  logic state_q;
  logic state_d;
  logic state_en;

  always_comb begin
    all_high  = &flags_i;
    none_high = ~|flags_i;
    state_d   = state_q;
    if (!active_i)      state_d = 1'b0;
    else if (all_high)  state_d = 1'b1;
    else if (none_high) state_d = 1'b0;
    state_en  = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= 1'b0;
    else if (state_en) state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign state_q_o = state_q;

endmodule

// File: rtl/dv_policy.sv
module dv_policy
  import dv_pkg::*;
(
  input  dv_mode_e  mode_i,
  input  dv_flags_t flags_i,
  input  logic      slow_d_i,
  output logic      valid_d_o
);

  always_comb begin
    unique case (mode_i)
      DV_ALWAYS: valid_d_o = 1'b1;
      DV_SLOW:   valid_d_o = slow_d_i;
      DV_MEDIUM: valid_d_o = flags_i.lock & (flags_i.rssi | flags_i.qual);
      DV_FAST:   valid_d_o = flags_i.qual;
      default:   valid_d_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dv_valid_gen.sv
module dv_valid_gen
  import dv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DV_MODE_W-1:0] mode_i,
  input  logic                 rssi_i,
  input  logic                 qual_i,
  input  logic                 lock_i,
  output logic                 valid_o
);

  logic      rst_core_n;
  dv_mode_e  mode;
  dv_flags_t flags;
  logic      slow_active;
  logic      slow_d;
  logic      slow_q;
  logic      valid_d;
  logic      valid_q;
  logic      valid_en;

  dv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  always_comb begin
    mode        = dv_mode_e'(mode_i);
    flags.rssi  = rssi_i;
    flags.qual  = qual_i;
    flags.lock  = lock_i;
    slow_active = (mode == DV_SLOW);
  end

  dv_hyst_latch u_hyst (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .active_i  (slow_active),
    .flags_i   (flags),
    .state_d_o (slow_d),
    .state_q_o (slow_q)
  );

  dv_policy u_pol (
    .mode_i    (mode),
    .flags_i   (flags),
    .slow_d_i  (slow_d),
    .valid_d_o (valid_d)
  );

  always_comb valid_en = (valid_d != valid_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/dv_valid_gen_chk.sv
module dv_valid_gen_chk
  import dv_pkg::*;
(
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [DV_MODE_W-1:0] mode_i,
  input logic                 rssi_i,
  input logic                 qual_i,
  input logic                 lock_i,
  input logic                 valid_o,
  input logic                 slow_q
);

  logic all_in;
  logic none_in;
  always_comb begin
    all_in  = rssi_i & qual_i & lock_i;
    none_in = ~(rssi_i | qual_i | lock_i);
  end

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_core_n |-> !valid_o);

  a_r2_always_high: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_ALWAYS) |=> valid_o);

  a_r3_slow_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_SLOW && all_in) |=> valid_o);

  a_r4_slow_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_SLOW && slow_q && !none_in) |=> valid_o);

  a_r5_slow_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_SLOW && none_in) |=> !valid_o);

  a_r6_medium: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_MEDIUM) |=> (valid_o == $past(lock_i & (rssi_i | qual_i))));

  a_r7_fast: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_FAST) |=> (valid_o == $past(qual_i)));

  a_r9_slow_entry: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == DV_SLOW && $past(mode_i) != DV_SLOW && !all_in) |=> !valid_o);

endmodule

bind dv_valid_gen dv_valid_gen_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .mode_i     (mode_i),
  .rssi_i     (rssi_i),
  .qual_i     (qual_i),
  .lock_i     (lock_i),
  .valid_o    (valid_o),
  .slow_q     (slow_q)
);

// File: tb/sim_dv_valid_gen.sv
module sim_dv_valid_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       rssi, qual, lock;
  logic       valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit m_slow = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  dv_valid_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .rssi_i  (rssi),
    .qual_i  (qual),
    .lock_i  (lock),
    .valid_o (valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: valid_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic r, input logic q,
                      input logic l, input string tag);
    item_t it;
    mode = m; rssi = r; qual = q; lock = l;
    if (m != 2'b01)       m_slow = 0;
    else if (r & q & l)   m_slow = 1;
    else if (!(r|q|l))    m_slow = 0;
    case (m)
      2'b00:   it.exp = 1'b1;
      2'b01:   it.exp = m_slow;
      2'b10:   it.exp = l & (r | q);
      default: it.exp = q;
    endcase
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(valid, it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: valid_o=%b expected=finish", valid);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 0; mode = 2'b00; rssi = 0; qual = 0; lock = 0;
    repeat (3) @(negedge clk);
    check(valid, 1'b0, "R1 held in reset");
    rst_n = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(valid, 1'b0, "R1 sync release latency");
    // R2 always high, any flags
    step(2'b00, 0, 0, 0, "R2 flags 000");
    step(2'b00, 1, 0, 1, "R2 flags 101");
    step(2'b00, 1, 1, 1, "R2 flags 111");
    // R9 entry without all flags: stays low
    step(2'b01, 1, 1, 0, "R9 entry partial");
    step(2'b01, 0, 1, 1, "R9 partial again");
    // R3 set
    step(2'b01, 1, 1, 1, "R3 set on all");
    // R4 hold while any high
    step(2'b01, 0, 1, 1, "R4 hold 011");
    step(2'b01, 0, 0, 1, "R4 hold 001");
    step(2'b01, 1, 0, 0, "R4 hold 100");
    step(2'b01, 0, 1, 0, "R4 hold 010");
    // R5 clear
    step(2'b01, 0, 0, 0, "R5 clear on none");
    step(2'b01, 1, 0, 1, "R5 stays clear partial");
    // R8 latency: set then check one-cycle delay via toggling
    step(2'b01, 1, 1, 1, "R8 set again");
    // R9 leave slow with latch set, come back with partial flags
    step(2'b10, 1, 1, 0, "R6 no lock");
    step(2'b01, 1, 0, 0, "R9 stale latch cleared");
    // R6 medium
    step(2'b10, 1, 0, 1, "R6 lock+rssi");
    step(2'b10, 0, 1, 1, "R6 lock+qual");
    step(2'b10, 0, 0, 1, "R6 lock only");
    step(2'b10, 1, 1, 1, "R6 all");
    step(2'b10, 1, 1, 0, "R6 lock lost");
    // R7 fast
    step(2'b11, 0, 1, 0, "R7 qual high");
    step(2'b11, 1, 0, 1, "R7 qual low");
    step(2'b11, 0, 1, 0, "R7 qual high again");
    step(2'b11, 0, 0, 0, "R8 follows next cycle");
    step(2'b00, 0, 0, 0, "R2 back to always");
    @(negedge clk); @(negedge clk);
    // R1 asynchronous drop mid-operation
    rst_n = 0;
    #1;
    check(valid, 1'b0, "R1 async drop");
    m_slow = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule